// File: doc/BRIEF.md
# Switching Protection Supervisor with Timed Auto-Restart

This block sits beside the pulse-width controller of an offline converter. It takes comparator flags that have already been digitized, a slow timebase strobe and a few switching markers. From them it decides when the power stage has to stop. Each fault source has its own qualification rule: some act at once, one must persist over a number of timebase ticks, one must repeat over consecutive switching cycles, one must repeat over consecutive zero-cross intervals, and one is judged only on the very first gate pulse.

When a qualified fault appears while switching is running, the block raises its shutdown output and records the code of that first fault. It then enters a hold period of a parameterised number of ticks. During the hold, a bias-enable output keeps the supply between a low and a high window flag. After the hold, the bias is withdrawn so the supply collapses to its turn-off level. At that point the block clears its fault code and waits for the supply to reach turn-on before switching is allowed again. Every qualification counter is cleared whenever switching is off.

Top module: `prot_supervisor`

## Requirements
- R1: After reset the block holds `sw_off_o`=1, `bias_en_o`=1 and `fault_code_o`=0. The first clock edge that samples `vdd_on_i`=1 enables switching (`sw_off_o`=0, `bias_en_o`=0).
- R2: While switching, `cs_ocp_i`=1 for a single clock sets `sw_off_o`=1 and `fault_code_o`=1 on that edge.
- R3: `vdd_ovp_i` held high through OVP_TICKS timebase ticks, and still high on the next edge, gives code 2. Releasing it after exactly OVP_TICKS ticks gives no fault.
- R4: While switching, `otp_i`=1 for one clock gives code 3 on that edge.
- R5: On a gate pulse marked by `first_pulse_i`, code 4 is raised when the gate falls if `cs_min_i` was never high while the gate was on. Later pulses are not checked.
- R6: `fb_ovp_i` held high continuously across FBOVP_CYCLES gate rising edges gives code 5. Fewer rising edges give no fault.
- R7: Code 6 is raised once OLP_ZC consecutive `zc_i` intervals have each contained at least one `cs_lim_i` event. An interval without an event restarts the count at zero.
- R8: `fb_low_i` held high through SHORT_TICKS ticks, and still high on the next edge, gives code 7. Clocks with `tick_i`=0 do not advance the window.
- R9: When several faults qualify on the same edge, the lowest code is recorded.
- R10: The first recorded code is held until supply collapse, and later faults do not change it. Qualification state gathered before a shutdown is discarded, so it does not count after the restart.
- R11: During the hold period `sw_off_o` stays 1. `bias_en_o` goes to 1 on `vdd_lo_i`, goes to 0 on `vdd_hi_i`, and otherwise keeps its value. The hold lasts RESTART_TICKS ticks.
- R12: After the hold, `bias_en_o`=0 until `vdd_uvlo_i`. `vdd_uvlo_i` then clears the code and sets `bias_en_o`=1, and `sw_off_o` stays 1 until `vdd_on_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase strobe for windows and hold timer |
| fb_low_i | input | 1 | Sampled feedback below short threshold (hysteretic) |
| fb_ovp_i | input | 1 | Sampled feedback above output over-voltage level |
| cs_ocp_i | input | 1 | Current sense above over-current level |
| cs_lim_i | input | 1 | Current sense reached cycle current limit |
| cs_min_i | input | 1 | Current sense above minimum sense level |
| vdd_ovp_i | input | 1 | Supply above over-voltage level |
| otp_i | input | 1 | Over-temperature comparator (hysteretic) |
| zc_i | input | 1 | Zero-cross strobe closing a line interval |
| gate_on_i | input | 1 | Gate drive is on |
| first_pulse_i | input | 1 | Current gate pulse is the first after start |
| vdd_lo_i | input | 1 | Supply below lower regulation window |
| vdd_hi_i | input | 1 | Supply above upper regulation window |
| vdd_uvlo_i | input | 1 | Supply at turn-off level |
| vdd_on_i | input | 1 | Supply at turn-on level |
| sw_off_o | output | 1 | Switching shutdown |
| bias_en_o | output | 1 | Supply bias regulation enable |
| fault_code_o | output | 3 | Code of first fault, 0 when none |

## Verification
Each qualified fault source is driven twice: once with a pattern that stops one step short of its threshold, and once with a pattern that just reaches it. This separates an off-by-one in every window, count and first-pulse rule from a correct trip. The zero-cross count is also run with one event-free interval in the middle, to show that the count restarts instead of pausing. The persistence window is run with the timebase held low, to show that it advances only on ticks. A random sequence of fault kinds and near-threshold or at-threshold patterns checks the recorded code against the expected one. Simultaneous faults check the priority rule, a fault injected during the hold checks the latch, and a full hold, collapse and re-entry sequence checks the bias window and the discarding of earlier qualification state.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    FC_NONE   = 3'd0,
    FC_OCP    = 3'd1,
    FC_VDDOV  = 3'd2,
    FC_OTP    = 3'd3,
    FC_SENSE  = 3'd4,
    FC_FBOV   = 3'd5,
    FC_OLOAD  = 3'd6,
    FC_SHORT  = 3'd7
  } fault_e;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_RUN   = 2'd1,
    ST_HOLD  = 2'd2,
    ST_DRAIN = 2'd3
  } sup_state_e;
endpackage

// File: rtl/prot_persist.sv
// Counts steps while a condition stays high; trips once LIMIT steps are seen.
module prot_persist #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cond,
  input  logic step,
  output logic trip
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en || !cond) cnt_q <= '0;
    else if (step && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign trip = en & cond & (cnt_q == LIM);
endmodule

// File: rtl/prot_olp_count.sv
// Counts consecutive zero-cross intervals that each held a current-limit event.
module prot_olp_count #(
  parameter int INTERVALS = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic lim_evt,
  input  logic zc,
  output logic trip
);
  localparam int CW = $clog2(INTERVALS + 1);
  localparam logic [CW-1:0] LIM = CW'(INTERVALS);

  logic [CW-1:0] cnt_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (zc) begin
      seen_q <= 1'b0;
      if (seen_q || lim_evt) begin
        if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end else if (lim_evt) begin
      seen_q <= 1'b1;
    end
  end

  assign trip = en & (cnt_q == LIM);
endmodule

// File: rtl/prot_sense_check.sv
// Judges the first gate pulse: current sense must exceed its minimum level.
module prot_sense_check (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic first_pulse,
  input  logic gate_on,
  input  logic gate_fall,
  input  logic cs_min,
  output logic trip
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst || !en) seen_q <= 1'b0;
    else if (first_pulse && gate_on && cs_min) seen_q <= 1'b1;
  end

  assign trip = en & first_pulse & gate_fall & ~seen_q;
endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor
  import prot_pkg::*;
#(
  parameter int SHORT_TICKS   = 35000,
  parameter int OVP_TICKS     = 10,
  parameter int FBOVP_CYCLES  = 4,
  parameter int OLP_ZC        = 60,
  parameter int RESTART_TICKS = 3000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              fb_low_i,
  input  logic              fb_ovp_i,
  input  logic              cs_ocp_i,
  input  logic              cs_lim_i,
  input  logic              cs_min_i,
  input  logic              vdd_ovp_i,
  input  logic              otp_i,
  input  logic              zc_i,
  input  logic              gate_on_i,
  input  logic              first_pulse_i,
  input  logic              vdd_lo_i,
  input  logic              vdd_hi_i,
  input  logic              vdd_uvlo_i,
  input  logic              vdd_on_i,
  output logic              sw_off_o,
  output logic              bias_en_o,
  output logic [CODE_W-1:0] fault_code_o
);
  localparam int HOLD_W = $clog2(RESTART_TICKS + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RESTART_TICKS - 1);

  sup_state_e        state_q, state_d;
  fault_e            code_q, code_d, trip_code;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              bias_q, bias_d;
  logic              off_q;
  logic              run_en;
  logic              gate_q, gate_rise, gate_fall;
  logic              t_vddov, t_fbov, t_short, t_oload, t_sense;

  assign run_en = (state_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate_on_i;
  end
  assign gate_rise = gate_on_i & ~gate_q;
  assign gate_fall = ~gate_on_i & gate_q;

  prot_persist #(.LIMIT(OVP_TICKS)) u_vddov (
    .clk(clk), .rst(rst), .en(run_en), .cond(vdd_ovp_i), .step(tick_i), .trip(t_vddov)
  );
  prot_persist #(.LIMIT(FBOVP_CYCLES)) u_fbov (
    .clk(clk), .rst(rst), .en(run_en), .cond(fb_ovp_i), .step(gate_rise), .trip(t_fbov)
  );
  prot_persist #(.LIMIT(SHORT_TICKS)) u_short (
    .clk(clk), .rst(rst), .en(run_en), .cond(fb_low_i), .step(tick_i), .trip(t_short)
  );
  prot_olp_count #(.INTERVALS(OLP_ZC)) u_oload (
    .clk(clk), .rst(rst), .en(run_en), .lim_evt(cs_lim_i), .zc(zc_i), .trip(t_oload)
  );
  prot_sense_check u_sense (
    .clk(clk), .rst(rst), .en(run_en), .first_pulse(first_pulse_i),
    .gate_on(gate_on_i), .gate_fall(gate_fall), .cs_min(cs_min_i), .trip(t_sense)
  );

  // Lowest code wins when several sources qualify together.
  always_comb begin
    if      (run_en && cs_ocp_i) trip_code = FC_OCP;
    else if (t_vddov)            trip_code = FC_VDDOV;
    else if (run_en && otp_i)    trip_code = FC_OTP;
    else if (t_sense)            trip_code = FC_SENSE;
    else if (t_fbov)             trip_code = FC_FBOV;
    else if (t_oload)            trip_code = FC_OLOAD;
    else if (t_short)            trip_code = FC_SHORT;
    else                         trip_code = FC_NONE;
  end

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    hold_d  = hold_q;
    bias_d  = bias_q;
    case (state_q)
      ST_WAIT: begin
        bias_d = 1'b1;
        if (vdd_on_i) begin
          state_d = ST_RUN;
          bias_d  = 1'b0;
        end
      end
      ST_RUN: begin
        bias_d = 1'b0;
        if (trip_code != FC_NONE) begin
          state_d = ST_HOLD;
          code_d  = trip_code;
          hold_d  = '0;
        end
      end
      ST_HOLD: begin
        if (vdd_lo_i)      bias_d = 1'b1;
        else if (vdd_hi_i) bias_d = 1'b0;
        if (tick_i) begin
          if (hold_q == HOLD_LAST) begin
            state_d = ST_DRAIN;
            bias_d  = 1'b0;
          end else begin
            hold_d = hold_q + 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        bias_d = 1'b0;
        if (vdd_uvlo_i) begin
          state_d = ST_WAIT;
          code_d  = FC_NONE;
          bias_d  = 1'b1;
        end
      end
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAIT;
      code_q  <= FC_NONE;
      hold_q  <= '0;
      bias_q  <= 1'b1;
      off_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      hold_q  <= hold_d;
      bias_q  <= bias_d;
      off_q   <= (state_d != ST_RUN);
    end
  end

  assign sw_off_o     = off_q;
  assign bias_en_o    = bias_q;
  assign fault_code_o = code_q;
endmodule

// File: rtl/prot_supervisor_chk.sv
module prot_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_ocp_i,
  input logic       otp_i,
  input logic       vdd_uvlo_i,
  input logic       vdd_on_i,
  input logic       sw_off_o,
  input logic       bias_en_o,
  input logic [2:0] fault_code_o
);
  a_r2_ocp_immediate: assert property (@(posedge clk) disable iff (rst)
    (!sw_off_o && cs_ocp_i) |=> (sw_off_o && fault_code_o == 3'd1));

  a_r4_otp_stops: assert property (@(posedge clk) disable iff (rst)
    (!sw_off_o && otp_i) |=> (sw_off_o && fault_code_o != 3'd0));

  a_r10_code_held: assert property (@(posedge clk) disable iff (rst)
    (fault_code_o != 3'd0 && !vdd_uvlo_i) |=> $stable(fault_code_o));

  a_r10_code_means_off: assert property (@(posedge clk) disable iff (rst)
    (fault_code_o != 3'd0) |-> sw_off_o);

  a_r12_restart_on_turnon: assert property (@(posedge clk) disable iff (rst)
    $fell(sw_off_o) |-> $past(vdd_on_i));

  a_r12_no_bias_running: assert property (@(posedge clk) disable iff (rst)
    !sw_off_o |-> !bias_en_o);
endmodule

bind prot_supervisor prot_supervisor_chk u_chk (
  .clk(clk), .rst(rst), .cs_ocp_i(cs_ocp_i), .otp_i(otp_i),
  .vdd_uvlo_i(vdd_uvlo_i), .vdd_on_i(vdd_on_i), .sw_off_o(sw_off_o),
  .bias_en_o(bias_en_o), .fault_code_o(fault_code_o)
);

// File: tb/prot_supervisor_tb.sv
module prot_supervisor_tb_top;
  localparam int CLK_P   = 10;
  localparam int SHORT_T = 12;
  localparam int OVP_T   = 5;
  localparam int FBOV_N  = 4;
  localparam int OLP_N   = 6;
  localparam int HOLD_T  = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b1, fb_low_i = 0, fb_ovp_i = 0, cs_ocp_i = 0, cs_lim_i = 0;
  logic cs_min_i = 0, vdd_ovp_i = 0, otp_i = 0, zc_i = 0, gate_on_i = 0;
  logic first_pulse_i = 0, vdd_lo_i = 0, vdd_hi_i = 0, vdd_uvlo_i = 0, vdd_on_i = 0;
  logic sw_off_o, bias_en_o;
  logic [2:0] fault_code_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  prot_supervisor #(
    .SHORT_TICKS(SHORT_T), .OVP_TICKS(OVP_T), .FBOVP_CYCLES(FBOV_N),
    .OLP_ZC(OLP_N), .RESTART_TICKS(HOLD_T)
  ) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .fb_low_i(fb_low_i), .fb_ovp_i(fb_ovp_i),
    .cs_ocp_i(cs_ocp_i), .cs_lim_i(cs_lim_i), .cs_min_i(cs_min_i), .vdd_ovp_i(vdd_ovp_i),
    .otp_i(otp_i), .zc_i(zc_i), .gate_on_i(gate_on_i), .first_pulse_i(first_pulse_i),
    .vdd_lo_i(vdd_lo_i), .vdd_hi_i(vdd_hi_i), .vdd_uvlo_i(vdd_uvlo_i), .vdd_on_i(vdd_on_i),
    .sw_off_o(sw_off_o), .bias_en_o(bias_en_o), .fault_code_o(fault_code_o)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int exp_code(int kind, bit over);
    return over ? kind : 0;
  endfunction

  task automatic bring_up(bit check_reset);
    rst = 1'b1;
    {fb_low_i, fb_ovp_i, cs_ocp_i, cs_lim_i, cs_min_i, vdd_ovp_i, otp_i, zc_i} = '0;
    {gate_on_i, first_pulse_i, vdd_lo_i, vdd_hi_i, vdd_uvlo_i, vdd_on_i} = '0;
    tick_i = 1'b1;
    step(2);
    rst = 1'b0;
    step(2);
    if (check_reset) begin
      chk("R1 reset sw_off", sw_off_o, 1);
      chk("R1 reset bias", bias_en_o, 1);
      chk("R1 reset code", fault_code_o, 0);
    end
    vdd_on_i = 1'b1;
    step(1);
    vdd_on_i = 1'b0;
    if (check_reset) begin
      chk("R1 run sw_off", sw_off_o, 0);
      chk("R12 run bias", bias_en_o, 0);
    end
  endtask

  task automatic hold_flag(int kind, int edges);
    if (kind == 2) vdd_ovp_i = 1'b1; else fb_low_i = 1'b1;
    step(edges);
    vdd_ovp_i = 1'b0;
    fb_low_i  = 1'b0;
  endtask

  task automatic gate_pulses(int n);
    for (int i = 0; i < n; i++) begin
      gate_on_i = 1'b1; step(1);
      gate_on_i = 1'b0; step(1);
    end
  endtask

  task automatic olp_intervals(int n, bit with_evt);
    for (int i = 0; i < n; i++) begin
      cs_lim_i = with_evt; step(1);
      cs_lim_i = 1'b0; zc_i = 1'b1; step(1);
      zc_i = 1'b0;
    end
  endtask

  task automatic first_pulse(bit sense_ok);
    first_pulse_i = 1'b1;
    gate_on_i = 1'b1; step(1);
    cs_min_i = sense_ok; step(1);
    cs_min_i = 1'b0; step(1);
    gate_on_i = 1'b0; step(1);
    first_pulse_i = 1'b0;
  endtask

  task automatic apply_fault(int kind, bit over);
    case (kind)
      1: begin if (over) cs_ocp_i = 1'b1; else cs_lim_i = 1'b1; step(1); cs_ocp_i = 0; cs_lim_i = 0; end
      2: hold_flag(2, over ? OVP_T + 1 : OVP_T);
      3: begin otp_i = over; step(1); otp_i = 1'b0; end
      4: first_pulse(!over);
      5: begin fb_ovp_i = 1'b1; gate_pulses(over ? FBOV_N : FBOV_N - 1); fb_ovp_i = 1'b0; end
      6: olp_intervals(over ? OLP_N : OLP_N - 1, 1'b1);
      default: hold_flag(7, over ? SHORT_T + 1 : SHORT_T);
    endcase
    step(2);
  endtask

  initial begin
    void'($urandom(32'd2718));

    // R1 / R2
    bring_up(1'b1);
    cs_ocp_i = 1'b1; step(1); cs_ocp_i = 1'b0;
    chk("R2 ocp code", fault_code_o, 1);
    chk("R2 ocp sw_off", sw_off_o, 1);

    // R9 simultaneous
    bring_up(1'b0);
    cs_ocp_i = 1'b1; otp_i = 1'b1; step(1); cs_ocp_i = 0; otp_i = 0;
    chk("R9 priority code", fault_code_o, 1);

    // R4
    bring_up(1'b0);
    otp_i = 1'b1; step(1); otp_i = 1'b0;
    chk("R4 otp code", fault_code_o, 3);

    // R3 boundary
    bring_up(1'b0);
    apply_fault(2, 1'b0);
    chk("R3 supply ovp short of window", fault_code_o, 0);
    apply_fault(2, 1'b1);
    chk("R3 supply ovp window met", fault_code_o, 2);

    // R8 timebase gating then trip
    bring_up(1'b0);
    tick_i = 1'b0;
    hold_flag(7, 3 * SHORT_T);
    tick_i = 1'b1;
    step(2);
    chk("R8 no tick no trip", fault_code_o, 0);
    apply_fault(7, 1'b0);
    chk("R8 short one tick short", fault_code_o, 0);
    apply_fault(7, 1'b1);
    chk("R8 short window met", fault_code_o, 7);

    // R6
    bring_up(1'b0);
    apply_fault(5, 1'b0);
    chk("R6 fb ovp too few cycles", fault_code_o, 0);
    apply_fault(5, 1'b1);
    chk("R6 fb ovp cycles met", fault_code_o, 5);

    // R7 with a missed interval
    bring_up(1'b0);
    olp_intervals(OLP_N - 1, 1'b1);
    olp_intervals(1, 1'b0);
    olp_intervals(OLP_N - 1, 1'b1);
    step(2);
    chk("R7 miss restarts count", fault_code_o, 0);
    olp_intervals(1, 1'b1);
    step(2);
    chk("R7 overload count met", fault_code_o, 6);

    // R5
    bring_up(1'b0);
    apply_fault(4, 1'b0);
    chk("R5 first pulse sensed ok", fault_code_o, 0);
    gate_on_i = 1'b1; step(3); gate_on_i = 1'b0; step(2);
    chk("R5 later pulse ignored", fault_code_o, 0);
    bring_up(1'b0);
    apply_fault(4, 1'b1);
    chk("R5 first pulse no sense", fault_code_o, 4);

    // R10 / R11 / R12 restart sequence
    bring_up(1'b0);
    olp_intervals(OLP_N - 1, 1'b1);
    cs_ocp_i = 1'b1; step(1); cs_ocp_i = 1'b0;          // hold edge 0
    chk("R10 first code", fault_code_o, 1);
    otp_i = 1'b1; step(1); otp_i = 1'b0;                 // edge 1
    chk("R10 later fault ignored", fault_code_o, 1);
    vdd_lo_i = 1'b1; step(1);                            // edge 2
    chk("R11 bias on at low", bias_en_o, 1);
    vdd_lo_i = 1'b0; vdd_hi_i = 1'b1; step(1);           // edge 3
    chk("R11 bias off at high", bias_en_o, 0);
    vdd_hi_i = 1'b0; step(1);                            // edge 4
    chk("R11 bias kept in window", bias_en_o, 0);
    vdd_lo_i = 1'b1;
    step(HOLD_T - 5);                                    // edge HOLD_T-1
    chk("R11 still holding bias", bias_en_o, 1);
    chk("R11 still off", sw_off_o, 1);
    step(1);                                             // edge HOLD_T
    chk("R12 bias released", bias_en_o, 0);
    step(3);
    chk("R12 bias stays released", bias_en_o, 0);
    chk("R10 code kept to collapse", fault_code_o, 1);
    vdd_lo_i = 1'b0; vdd_uvlo_i = 1'b1; step(1); vdd_uvlo_i = 1'b0;
    chk("R12 code cleared", fault_code_o, 0);
    chk("R12 bias for startup", bias_en_o, 1);
    step(3);
    chk("R12 waits for turn-on", sw_off_o, 1);
    vdd_on_i = 1'b1; step(1); vdd_on_i = 1'b0;
    chk("R12 restarted", sw_off_o, 0);
    olp_intervals(1, 1'b1);
    step(2);
    chk("R10 old count discarded", fault_code_o, 0);

    // Random mix
    for (int it = 0; it < 28; it++) begin
      int  kind;
      bit  over;
      kind = 1 + int'($urandom_range(6));
      over = bit'($urandom_range(1));
      bring_up(1'b0);
      apply_fault(kind, over);
      chk($sformatf("R9 random kind %0d over %0d code", kind, over), fault_code_o, exp_code(kind, over));
      chk("R10 random off matches code", sw_off_o, (exp_code(kind, over) != 0) ? 1 : 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule